// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a 32-bit down-counter that counts prescaled ticks of its base clock. Software loads a start value, chooses a power-of-two prescale through a small divide field, and sets up a control entry. The entry holds a periodic-mode bit, a mask bit and an 8-bit vector. Each time the count runs out, the block raises a strobe for one cycle and presents the vector on a side output. It can fire once (one-shot) or keep reloading (periodic). The live count value is always visible on a read port.

The sequencing is a three-state machine. ST_IDLE is the state after reset, where nothing counts. ST_RUN is the counting state. ST_HOLD is the state a finished one-shot waits in at zero. A start-value write moves the machine to ST_RUN from any state (transition LOAD). In ST_RUN, a tick at zero in periodic mode reloads the count and stays in ST_RUN (transition RELOAD). A tick at zero in one-shot mode moves to ST_HOLD (transition FINISH).

The prescaler restarts its phase on every start-value write. Elapsed ticks are therefore always counted from the moment of the load.

Top module: `tick_timer`

## Requirements
- R1: After reset the current count reads 0, the strobe is low and the divide readback is 0. The control entry is masked, so a count loaded before any entry write produces no strobe.
- R2: A divide write keeps only bits 0, 1 and 3 of the written word (mask 0xB). The readback shows exactly those bits, and all other bits read 0.
- R3: The divide code is {bit3, bit1, bit0}. The tick period is 2^((code+1) mod 8) base cycles, so code 7 gives one tick per cycle and codes 0 to 6 give periods of 2 to 128.
- R4: In the control entry, bit 17 = 1 selects periodic mode, bit 16 = 1 masks the strobe, and bits [7:0] carry the vector.
- R5: A start-value write of N loads the count with N on the next cycle and restarts the prescale phase. A second write discards the progress made under the first.
- R6: In one-shot mode with N > 0, the count drops by one per tick and holds at 0. Exactly one strobe fires, at the edge of tick N+1 after the load. With N = 0 in one-shot mode, no strobe fires.
- R7: In periodic mode the count, after k ticks, equals N - (k mod (N+1)). A strobe fires every N+1 ticks.
- R8: A periodic start value of 0 produces no strobe. A masked entry produces no strobe, while the count keeps running.
- R9: A control-entry write does not restart the count. If an entry is unmasked while counting, it fires at the originally scheduled tick, and the strobe carries the vector of the entry in force at that tick.
- R10: Each expiry yields a strobe that is high for exactly one cycle, with irq_vector equal to the entry's vector.
- R11: Writes to the current count are ignored, and the count continues on its own schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_wr | input | 1 | Start-value write strobe |
| init_data | input | 32 | Start value |
| div_wr | input | 1 | Divide write strobe |
| div_data | input | 32 | Divide word; bits 3, 1 and 0 are kept |
| entry_wr | input | 1 | Control-entry write strobe |
| entry_data | input | 32 | Control entry: [17] periodic, [16] mask, [7:0] vector |
| count_wr | input | 1 | Write strobe for the current count (ignored) |
| count_wdata | input | 32 | Data for the current count (ignored) |
| cur_count | output | 32 | Live count value |
| div_readback | output | 32 | Stored divide bits |
| irq_fire | output | 1 | One-cycle expiry strobe |
| irq_vector | output | 8 | Vector that goes with the strobe |

## Verification
The main check is a table of divide words, with one row for every divide code. Each row pairs a word with a small start value. The exact cycle of the single one-shot strobe then separates all eight prescale periods and exposes off-by-one errors in the N+1 expiry point.

Periodic runs at two prescale settings compare the strobe count with the live count value. This distinguishes a reload to N from a reload to N-1.

Masked runs, a zero periodic start value, and a mid-count unmask show whether the count and the strobe are gated independently. A restart, an ignored count write and an oversized divide word cover the remaining paths.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int ENT_PERIODIC_BIT = 17;
    localparam int ENT_MASK_BIT     = 16;
    localparam int VEC_W            = 8;
    localparam int CODE_W           = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } run_state_e;

    function automatic logic [CODE_W-1:0] code_to_shift(input logic [CODE_W-1:0] code);
        return code + CODE_W'(1);
    endfunction

endpackage

// File: rtl/tick_timer_divcfg.sv
module tick_timer_divcfg
    import tick_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_wr,
    input  logic [3:0]        div_low,
    output logic [CODE_W-1:0] shift,
    output logic [31:0]       readback
);
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (div_wr) begin
            code_q <= {div_low[3], div_low[1:0]};
        end
    end

    assign shift    = code_to_shift(code_q);
    assign readback = {28'd0, code_q[2], 1'b0, code_q[1:0]};

    logic unused_div;
    assign unused_div = div_low[2];

endmodule

// File: rtl/tick_timer_prescale.sv
module tick_timer_prescale #(
    parameter int PRE_W = 7,
    localparam int SH_W = $clog2(PRE_W + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [SH_W-1:0] shift,
    output logic            tick
);
    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] low_mask;

    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign low_mask[i] = (shift > SH_W'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PRE_W'(1);
        end
    end

    assign tick = &(phase_q | ~low_mask);

endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    input  logic             masked,
    input  logic [VEC_W-1:0] vector,
    input  logic             entry_wr,
    output logic [CNT_W-1:0] count,
    output logic             fire,
    output logic [VEC_W-1:0] fire_vec
);
    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] reload_q;
    logic             armed_q, armed_d;
    logic             fire_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        armed_d = armed_q;
        fire_d  = 1'b0;
        if (load) begin
            state_d = ST_RUN;
            cnt_d   = load_val;
            armed_d = (load_val != '0);
        end else begin
            if (entry_wr) begin
                armed_d = (cnt_q != '0);
            end
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_RUN: begin
                    if (tick) begin
                        if (cnt_q != '0) begin
                            cnt_d = cnt_q - CNT_W'(1);
                        end else if (periodic) begin
                            cnt_d  = reload_q;
                            fire_d = !masked && (reload_q != '0);
                        end else begin
                            fire_d  = !masked && armed_q;
                            state_d = ST_HOLD;
                        end
                    end
                end
                ST_HOLD: begin
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            reload_q <= '0;
            armed_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            armed_q <= armed_d;
            if (load) begin
                reload_q <= load_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fire     <= 1'b0;
            fire_vec <= '0;
        end else begin
            fire <= fire_d;
            if (fire_d) begin
                fire_vec <= vector;
            end
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_wr,
    input  logic [CNT_W-1:0] init_data,
    input  logic             div_wr,
    input  logic [31:0]      div_data,
    input  logic             entry_wr,
    input  logic [31:0]      entry_data,
    input  logic             count_wr,
    input  logic [31:0]      count_wdata,
    output logic [CNT_W-1:0] cur_count,
    output logic [31:0]      div_readback,
    output logic             irq_fire,
    output logic [VEC_W-1:0] irq_vector
);
    localparam int SH_W = $clog2(PRE_W + 1);

    logic             ent_periodic_q;
    logic             ent_mask_q;
    logic [VEC_W-1:0] ent_vec_q;
    logic [CODE_W-1:0] shift_raw;
    logic [SH_W-1:0]  shift;
    logic             tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_periodic_q <= 1'b0;
            ent_mask_q     <= 1'b1;
            ent_vec_q      <= '0;
        end else if (entry_wr) begin
            ent_periodic_q <= entry_data[ENT_PERIODIC_BIT];
            ent_mask_q     <= entry_data[ENT_MASK_BIT];
            ent_vec_q      <= entry_data[VEC_W-1:0];
        end
    end

    tick_timer_divcfg u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_wr   (div_wr),
        .div_low  (div_data[3:0]),
        .shift    (shift_raw),
        .readback (div_readback)
    );

    assign shift = SH_W'(shift_raw);

    tick_timer_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (init_wr),
        .shift   (shift),
        .tick    (tick)
    );

    tick_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (init_wr),
        .load_val (init_data),
        .tick     (tick),
        .periodic (ent_periodic_q),
        .masked   (ent_mask_q),
        .vector   (ent_vec_q),
        .entry_wr (entry_wr),
        .count    (cur_count),
        .fire     (irq_fire),
        .fire_vec (irq_vector)
    );

    logic unused_inputs;
    assign unused_inputs = ^{div_data[31:4], entry_data[31:18], entry_data[15:VEC_W],
                             count_wr, count_wdata};

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_wr,
    input logic [CNT_W-1:0] init_data,
    input logic             div_wr,
    input logic [31:0]      div_data,
    input logic             entry_wr,
    input logic [31:0]      entry_data,
    input logic [CNT_W-1:0] cur_count,
    input logic [31:0]      div_readback,
    input logic             irq_fire,
    input logic [7:0]       irq_vector
);
    logic       sh_mask_q;
    logic [7:0] sh_vec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_mask_q <= 1'b1;
            sh_vec_q  <= '0;
        end else if (entry_wr) begin
            sh_mask_q <= entry_data[16];
            sh_vec_q  <= entry_data[7:0];
        end
    end

    logic unused_chk;
    assign unused_chk = ^{entry_data[31:17], entry_data[15:8]};

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fire |=> !irq_fire); // R10

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> cur_count == $past(init_data)); // R5

    AST_NO_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_wr && cur_count != '0) |=> cur_count <= $past(cur_count)); // R6

    AST_FIRE_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fire |-> $past(cur_count) == '0); // R7

    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fire |-> !$past(sh_mask_q)); // R8

    AST_FIRE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fire |-> irq_vector == $past(sh_vec_q)); // R10

    AST_DIV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> div_readback == ($past(div_data) & 32'h0000_000B)); // R2

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_wr      (init_wr),
    .init_data    (init_data),
    .div_wr       (div_wr),
    .div_data     (div_data),
    .entry_wr     (entry_wr),
    .entry_data   (entry_data),
    .cur_count    (cur_count),
    .div_readback (div_readback),
    .irq_fire     (irq_fire),
    .irq_vector   (irq_vector)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_wr = 1'b0;
    logic [31:0] init_data = '0;
    logic        div_wr = 1'b0;
    logic [31:0] div_data = '0;
    logic        entry_wr = 1'b0;
    logic [31:0] entry_data = '0;
    logic        count_wr = 1'b0;
    logic [31:0] count_wdata = '0;
    logic [31:0] cur_count;
    logic [31:0] div_readback;
    logic        irq_fire;
    logic [7:0]  irq_vector;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int load_cyc = 0;
    int fire_cnt = 0;
    int last_fire_cyc = 0;
    logic [7:0] last_vec = '0;

    localparam logic [31:0] E_MASKED   = 32'h0001_0000;
    localparam logic [31:0] E_PERIODIC = 32'h0002_0000;

    // {divide word[7:0], start value[7:0], expected tick period[15:0]}
    localparam int NROWS = 8;
    localparam logic [31:0] VEC_TBL [NROWS] = '{
        {8'h0B, 8'd5, 16'd1},
        {8'h00, 8'd3, 16'd2},
        {8'h01, 8'd2, 16'd4},
        {8'h02, 8'd1, 16'd8},
        {8'h03, 8'd2, 16'd16},
        {8'h08, 8'd1, 16'd32},
        {8'h09, 8'd1, 16'd64},
        {8'h0A, 8'd2, 16'd128}
    };

    tick_timer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_wr      (init_wr),
        .init_data    (init_data),
        .div_wr       (div_wr),
        .div_data     (div_data),
        .entry_wr     (entry_wr),
        .entry_data   (entry_data),
        .count_wr     (count_wr),
        .count_wdata  (count_wdata),
        .cur_count    (cur_count),
        .div_readback (div_readback),
        .irq_fire     (irq_fire),
        .irq_vector   (irq_vector)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (irq_fire) begin
            fire_cnt      = fire_cnt + 1;
            last_fire_cyc = cyc;
            last_vec      = irq_vector;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // sel: 0 start value, 1 divide, 2 entry, 3 current count
    task automatic reg_write(input int sel, input logic [31:0] v);
        @(negedge clk);
        case (sel)
            0: begin init_data = v; init_wr = 1'b1; end
            1: begin div_data = v; div_wr = 1'b1; end
            2: begin entry_data = v; entry_wr = 1'b1; end
            default: begin count_wdata = v; count_wr = 1'b1; end
        endcase
        @(posedge clk);
        @(negedge clk);
        init_wr = 1'b0; div_wr = 1'b0; entry_wr = 1'b0; count_wr = 1'b0;
        if (sel == 0) load_cyc = cyc;
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiesce();
        reg_write(2, E_MASKED);
        reg_write(0, 32'd0);
        wait_neg(2);
    endtask

    task automatic start(input logic [31:0] dv, input logic [31:0] ent, input logic [31:0] n);
        quiesce();
        reg_write(1, dv);
        reg_write(2, ent);
        fire_cnt = 0;
        reg_write(0, n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(1);
        // R1 reset state
        chk("R1 count", cur_count, 32'd0);
        chk("R1 strobe", {31'd0, irq_fire}, 32'd0);
        chk("R1 divide", div_readback, 32'd0);
        reg_write(1, 32'h0B);
        fire_cnt = 0;
        reg_write(0, 32'd2);
        wait_neg(10);
        chk("R1 entry masked at reset", fire_cnt, 0);
        chk("R1 count held", cur_count, 32'd0);

        // R2 divide masking
        reg_write(1, 32'hFFFF_FFFF);
        chk("R2 readback all ones", div_readback, 32'h0000_000B);
        reg_write(1, 32'h0000_0004);
        chk("R2 readback bit2 only", div_readback, 32'd0);

        // R3 R6 R10: table of divide codes, one-shot
        for (int i = 0; i < NROWS; i++) begin
            logic [31:0] row;
            int n;
            int per;
            row = VEC_TBL[i];
            n   = int'(row[23:16]);
            per = int'(row[15:0]);
            start({24'd0, row[31:24]}, 32'h0000_0080 + 32'(i), 32'(n));
            wait_neg((n + 1) * per + 3);
            chk("R6 single strobe", fire_cnt, 1);
            chk("R3 expiry cycle", last_fire_cyc - load_cyc, (n + 1) * per);
            chk("R10 vector", {24'd0, last_vec}, 32'h80 + 32'(i));
            chk("R6 held at zero", cur_count, 32'd0);
        end

        // R5 R6 count trajectory
        start(32'h0B, 32'h21, 32'd4);
        chk("R5 loaded value", cur_count, 32'd4);
        wait_neg(2);
        chk("R6 count after two ticks", cur_count, 32'd2);
        wait_neg(8);
        chk("R6 one strobe", fire_cnt, 1);
        chk("R6 expiry at N+1", last_fire_cyc - load_cyc, 5);
        chk("R4 vector field", {24'd0, last_vec}, 32'h21);

        // R6 one-shot zero
        start(32'h0B, 32'h22, 32'd0);
        wait_neg(10);
        chk("R6 zero start no strobe", fire_cnt, 0);

        // R7 periodic, tick every cycle
        start(32'h0B, E_PERIODIC | 32'h44, 32'd2);
        wait_neg(13);
        chk("R7 strobe count", fire_cnt, 4);
        chk("R7 last expiry", last_fire_cyc - load_cyc, 12);
        chk("R7 count mod", cur_count, 32'd1);
        chk("R4 periodic vector", {24'd0, last_vec}, 32'h44);

        // R7 periodic with divide by 2
        start(32'h00, E_PERIODIC | 32'h45, 32'd1);
        wait_neg(17);
        chk("R7 strobes divided", fire_cnt, 4);
        chk("R7 last expiry divided", last_fire_cyc - load_cyc, 16);

        // R8 periodic zero, masked one-shot, masked periodic
        start(32'h0B, E_PERIODIC | 32'h46, 32'd0);
        wait_neg(20);
        chk("R8 periodic zero quiet", fire_cnt, 0);
        chk("R8 periodic zero count", cur_count, 32'd0);
        start(32'h0B, E_MASKED | 32'h47, 32'd3);
        wait_neg(10);
        chk("R8 masked one-shot quiet", fire_cnt, 0);
        chk("R8 masked count ran", cur_count, 32'd0);
        start(32'h0B, E_PERIODIC | E_MASKED | 32'h48, 32'd2);
        wait_neg(10);
        chk("R8 masked periodic quiet", fire_cnt, 0);
        chk("R8 masked periodic count", cur_count, 32'd1);

        // R9 unmask mid-count keeps schedule
        start(32'h0B, E_MASKED, 32'd10);
        reg_write(2, 32'h55);
        chk("R9 count not restarted", cur_count, 32'd8);
        wait_neg(12);
        chk("R9 one strobe", fire_cnt, 1);
        chk("R9 original schedule", last_fire_cyc - load_cyc, 11);
        chk("R9 new vector", {24'd0, last_vec}, 32'h55);

        // R5 restart discards progress
        start(32'h0B, 32'h66, 32'd5);
        reg_write(0, 32'd5);
        wait_neg(10);
        chk("R5 one strobe after restart", fire_cnt, 1);
        chk("R5 restart timing", last_fire_cyc - load_cyc, 6);

        // R11 count write ignored
        start(32'h0B, 32'h77, 32'd6);
        reg_write(3, 32'h0000_ABCD);
        chk("R11 count write ignored", cur_count, 32'd4);
        wait_neg(8);
        chk("R11 expiry unaffected", last_fire_cyc - load_cyc, 7);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule